// File: doc/BRIEF.md
# Partial Load Byte Merge Unit

This block sits in the load path of a 64-bit processor. It handles the loads that fetch an unaligned word or doubleword in two halves. Each half reads one aligned memory unit and combines some of its bytes with the bytes already in the destination register. Two such instructions, one per side, put together a value that crosses an alignment boundary.

Each request gives the block:
- the operation;
- the effective address;
- the current register value;
- the aligned memory data.

The block returns the address rounded down to the aligned boundary and the merged 64-bit register value. Both are registered and marked by a valid strobe one clock later.

The memory read, exception detection and register writeback are done by the surrounding pipeline. Memory data is big-endian: byte offset 0 of an aligned unit is its most significant byte.

Top module: `unaligned_load_merge`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `rt_out` and `aligned_addr` to zero.
- R2: `out_valid` equals `in_valid` of the previous clock edge. While `in_valid` is low, `rt_out` and `aligned_addr` keep their last values.
- R3: `aligned_addr` is `addr` with bits [1:0] cleared for word operations (op 00, 01) and with bits [2:0] cleared for doubleword operations (op 10, 11).
- R4: op 00 is the left-word merge, with offset n = addr[1:0]. The low 32-bit result is rt_in[31:0] masked to its low n bytes, OR-ed with mem_data[31:0] shifted left by 8n, truncated to 32 bits. Offset 0 takes the whole memory word.
- R5: The left-word result is always sign-extended from bit 31 into bits [63:32].
- R6: op 01 is the right-word merge. For n = addr[1:0] < 3, the low n+1 bytes of the result are mem_data[31:0] shifted right by 8(3-n). Every other byte, including bits [63:32], is taken unchanged from rt_in.
- R7: The right-word merge at offset 3 takes the whole memory word and sign-extends it from bit 31.
- R8: op 10 is the left-doubleword merge, with n = addr[2:0]. The result is rt_in masked to its low n bytes, OR-ed with mem_data shifted left by 8n. Offset 0 takes the whole doubleword.
- R9: op 11 is the right-doubleword merge. The low n+1 bytes of the result are mem_data shifted right by 8(7-n), and the rest comes from rt_in. Offset 7 takes the whole doubleword.
- R10: Word operations ignore mem_data[63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 left word, 01 right word, 10 left doubleword, 11 right doubleword |
| addr | input | ADDR_W | Effective byte address |
| rt_in | input | 64 | Current destination register value |
| mem_data | input | 64 | Aligned memory data, big-endian; word forms use [31:0] |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| aligned_addr | output | ADDR_W | Address rounded down to the access boundary |
| rt_out | output | 64 | Merged register value |

## Verification
Every operation is run at every byte offset. The register and memory operands have distinct byte values, so each result byte shows which source it came from and at what shift; a wrong shift amount or mask edge shows as a misplaced byte.

The word forms are run with memory words whose bit 31 is both clear and set. This separates the left form, which always sign-extends, from the right form, which extends only at offset 3 and otherwise keeps the register's upper half.

Word requests are repeated with garbage and with zeros in the unused upper memory half; the two results must match. Idle cycles with changing inputs show that the outputs hold.

// File: rtl/unaligned_load_merge.sv
module unaligned_load_merge #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       rt_in,
  input  logic [63:0]       mem_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] aligned_addr,
  output logic [63:0]       rt_out
);
  localparam logic [1:0] OP_LW = 2'b00, OP_RW = 2'b01, OP_LD = 2'b10;

  logic [1:0]  wofs;
  logic [2:0]  dofs;
  logic [4:0]  wl_sh, wr_sh;
  logic [5:0]  dl_sh, dr_sh;
  logic [31:0] mword, lw32, rw_take, rw32;
  logic [63:0] res_lw, res_rw, res_ld, res_rd, dr_take, merged;
  logic [ADDR_W-1:0] al_next;

  assign wofs  = addr[1:0];
  assign dofs  = addr[2:0];
  assign wl_sh = {wofs, 3'b000};
  assign wr_sh = {~wofs, 3'b000};
  assign dl_sh = {dofs, 3'b000};
  assign dr_sh = {~dofs, 3'b000};
  assign mword = mem_data[31:0];

  assign lw32   = (rt_in[31:0] & ((32'h1 << wl_sh) - 32'h1)) | (mword << wl_sh);
  assign res_lw = {{32{lw32[31]}}, lw32};

  assign rw_take = 32'hFFFF_FFFF >> wr_sh;
  assign rw32    = (rt_in[31:0] & ~rw_take) | (mword >> wr_sh);
  assign res_rw  = (wofs == 2'd3) ? {{32{mword[31]}}, mword} : {rt_in[63:32], rw32};

  assign res_ld = (rt_in & ((64'h1 << dl_sh) - 64'h1)) | (mem_data << dl_sh);

  assign dr_take = {64{1'b1}} >> dr_sh;
  assign res_rd  = (rt_in & ~dr_take) | (mem_data >> dr_sh);

  always_comb begin
    case (op)
      OP_LW:   merged = res_lw;
      OP_RW:   merged = res_rw;
      OP_LD:   merged = res_ld;
      default: merged = res_rd;
    endcase
  end

  assign al_next = op[1] ? {addr[ADDR_W-1:3], 3'b000} : {addr[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      aligned_addr <= '0;
      rt_out       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        aligned_addr <= al_next;
        rt_out       <= merged;
      end
    end
  end
endmodule

module unaligned_load_merge_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rt_hi,
  input logic [63:0]       mem_data,
  input logic              out_valid,
  input logic [ADDR_W-1:0] aligned_addr,
  input logic [63:0]       rt_out
);
  p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(rt_out) && $stable(aligned_addr)));
  p_word_align_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op[1]) |=> (aligned_addr[1:0] == 2'b00 &&
                              aligned_addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2])));
  p_dword_align_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[1]) |=> (aligned_addr[2:0] == 3'b000 &&
                             aligned_addr[ADDR_W-1:3] == $past(addr[ADDR_W-1:3])));
  p_left_sext_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> (rt_out[63:32] == {32{rt_out[31]}}));
  p_right_keep_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && addr[1:0] != 2'b11) |=> (rt_out[63:32] == $past(rt_hi)));
  p_right_full_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && addr[1:0] == 2'b11) |=>
      (rt_out == {{32{$past(mem_data[31])}}, $past(mem_data[31:0])}));
  p_left_dw_full_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && addr[2:0] == 3'b000) |=> (rt_out == $past(mem_data)));
  p_right_dw_full_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11 && addr[2:0] == 3'b111) |=> (rt_out == $past(mem_data)));
endmodule

bind unaligned_load_merge unaligned_load_merge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addr(addr),
  .rt_hi(rt_in[63:32]), .mem_data(mem_data), .out_valid(out_valid),
  .aligned_addr(aligned_addr), .rt_out(rt_out)
);

// File: tb/unaligned_load_merge_bench.sv
module unaligned_load_merge_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op;
  logic [31:0] addr;
  logic [63:0] rt_in, mem_data;
  logic        out_valid;
  logic [31:0] aligned_addr;
  logic [63:0] rt_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  unaligned_load_merge u_unaligned_load_merge (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addr(addr),
    .rt_in(rt_in), .mem_data(mem_data), .out_valid(out_valid),
    .aligned_addr(aligned_addr), .rt_out(rt_out)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(logic [63:0] v, int i);
    return v[8*i +: 8];
  endfunction

  function automatic logic [63:0] model(logic [1:0] o, logic [31:0] a,
                                        logic [63:0] r, logic [63:0] m);
    logic [63:0] res = r;
    int n;
    if (!o[1]) begin
      n = int'(a[1:0]);
      for (int i = 0; i < 4; i++) begin
        if (o == 2'b00) res[8*i +: 8] = (i < n) ? byte_of(r, i) : byte_of(m, i - n);
        else if (i <= n) res[8*i +: 8] = byte_of(m, i + 3 - n);
      end
      if (o == 2'b00 || n == 3) res[63:32] = {32{res[31]}};
    end else begin
      n = int'(a[2:0]);
      for (int i = 0; i < 8; i++) begin
        if (o == 2'b10) res[8*i +: 8] = (i < n) ? byte_of(r, i) : byte_of(m, i - n);
        else if (i <= n) res[8*i +: 8] = byte_of(m, i + 7 - n);
      end
    end
    return res;
  endfunction

  task automatic issue(logic [1:0] o, logic [31:0] a, logic [63:0] r, logic [63:0] m);
    @(negedge clk);
    in_valid = 1'b1; op = o; addr = a; rt_in = r; mem_data = m;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic run_one(string req, logic [1:0] o, logic [31:0] a,
                         logic [63:0] r, logic [63:0] m);
    logic [31:0] exp_a;
    exp_a = o[1] ? (a & 32'hFFFF_FFF8) : (a & 32'hFFFF_FFFC);
    issue(o, a, r, m);
    chk({req, " valid R2"}, {63'd0, out_valid}, 64'd1);
    chk({req, " data"}, rt_out, model(o, a, r, m));
    chk({req, " addr R3"}, {32'd0, aligned_addr}, {32'd0, exp_a});
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 rt_out", rt_out, 64'd0);
    chk("R1 aligned_addr", {32'd0, aligned_addr}, 64'd0);
  endtask

  task automatic t_left_word;
    for (int k = 0; k < 4; k++) begin
      run_one("R4 R5 left word pos", 2'b00, 32'h1000_0100 + k,
              64'hA1A2_A3A4_B1B2_B3B4, 64'hEEEE_EEEE_1122_3344);
      run_one("R4 R5 left word neg", 2'b00, 32'h2000_0204 + k,
              64'h0102_0304_0506_0708, 64'h5555_5555_C1C2_C3C4);
    end
  endtask

  task automatic t_right_word;
    for (int k = 0; k < 4; k++) begin
      run_one(k == 3 ? "R7 right word full pos" : "R6 right word pos", 2'b01,
              32'h3000_0010 + k, 64'hA1A2_A3A4_B1B2_B3B4, 64'h9999_9999_1122_3344);
      run_one(k == 3 ? "R7 right word full neg" : "R6 right word neg", 2'b01,
              32'h3000_0018 + k, 64'h0102_0304_0506_0708, 64'h7777_7777_D1D2_D3D4);
    end
  endtask

  task automatic t_left_dword;
    for (int k = 0; k < 8; k++)
      run_one("R8 left dword", 2'b10, 32'h4000_0020 + k,
              64'hA1A2_A3A4_A5A6_A7A8, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_right_dword;
    for (int k = 0; k < 8; k++)
      run_one(k == 7 ? "R9 right dword full" : "R9 right dword", 2'b11,
              32'h5000_0048 + k, 64'hA1A2_A3A4_A5A6_A7A8, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_upper_ignored;
    logic [63:0] with_junk;
    for (int o = 0; o < 2; o++) begin
      for (int k = 0; k < 4; k++) begin
        issue(o[1:0], 32'h6000_0000 + k, 64'hCAFE_F00D_1234_5678, 64'hDEAD_BEEF_8899_AABB);
        with_junk = rt_out;
        issue(o[1:0], 32'h6000_0000 + k, 64'hCAFE_F00D_1234_5678, 64'h0000_0000_8899_AABB);
        chk("R10 upper memory half ignored", with_junk, rt_out);
      end
    end
  endtask

  task automatic t_hold;
    logic [63:0] last_rt;
    logic [31:0] last_a;
    issue(2'b10, 32'h7000_0003, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    last_rt = rt_out; last_a = aligned_addr;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      op = 2'(c); addr = 32'h0BAD_0000 + c; rt_in = ~rt_in; mem_data = ~mem_data;
      @(posedge clk); #1;
      chk("R2 idle valid low", {63'd0, out_valid}, 64'd0);
      chk("R2 idle rt held", rt_out, last_rt);
      chk("R2 idle addr held", {32'd0, aligned_addr}, {32'd0, last_a});
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = 2'b00; addr = '0; rt_in = '0; mem_data = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_left_word();
    t_right_word();
    t_left_dword();
    t_right_dword();
    t_upper_ignored();
    t_hold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule